// File: doc/BRIEF.md
# SPI Dual-Space Register Port

This block is an SPI slave front end that gives an external host access to two register spaces inside the chip. The short space holds 64 byte registers. The long space holds 1024 byte registers. The first bit of every transaction picks the space. A short access sends one command byte. A long access sends a two-byte command. Data bytes follow the command for as long as chip select stays low, and the address steps forward by one after each data byte. A host can therefore stream a whole buffer in one transaction.

On the chip side the block drives a simple register bus. It provides a space flag, an address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data must be returned combinationally in the same cycle as the read strobe. The registers themselves live outside the block.

SCK, chip select and MOSI are brought into the system clock through two-stage synchronisers. The link runs in SPI mode 0 with MSB-first bytes. MOSI is captured on the rising SCK edge, and MISO is updated after the falling SCK edge. The system clock must run at least eight times faster than SCK. While chip select is high, MISO is driven low.

Top module: `spi_regport`

## Requirements
- R1: A first byte with bit 7 = 0 is a short command: bits 6:1 are the address, and bit 0 = 1 means write, 0 means read. The data phase starts with the second byte.
- R2: A first byte with bit 7 = 1 starts a long command. Across the two command bytes, bits 14:5 of the 16-bit word are the address and bit 4 = 1 means write. Bits 3:0 have no effect on the address or the direction.
- R3: In a write transaction, each completed data byte gives exactly one one-cycle write strobe. The strobe carries that byte and the current address, and `bus_long` shows the space.
- R4: In a read transaction, the register at the current address is fetched by a one-cycle read strobe once the address phase or the previous data byte completes. Its value is shifted out MSB first on MISO during the next byte.
- R5: After every data byte the address increases by one. In the long space it wraps from 1023 to 0.
- R6: In the short space the burst address wraps from 63 to 0, and a short-space strobe never carries an address above 63.
- R7: Raising chip select discards a partially received byte without any strobe. The next transaction is decoded from its first byte as a new command.
- R8: After reset, and whenever chip select is high, MISO is 0 and neither strobe is active.
- R9: MISO is 0 during command bytes and during the data bytes of a write transaction.
- R10: The write and read strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_long | output | 1 | 1 = long space, 0 = short space |
| bus_addr | output | 10 | Register address (upper bits 0 for short space) |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid in the cycle of `bus_rd` |

## Verification
The hardest cases to reach are the address wraps in the middle of a burst and a chip-select abort in the middle of a byte. Each needs a host that keeps clocking across a space boundary, or that stops between two SCK edges. The bench drives SCK bit by bit and has a behavioural register file on the bus side. It starts bursts two or three bytes below the top of each space, so the wrap lands inside one transaction. It also cuts a write after four data bits and then checks that the target register is unchanged and that the following transaction still decodes correctly.

// File: rtl/spi_regport.sv
module spi_regport (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       bus_long,
  output logic [9:0] bus_addr,
  output logic [7:0] bus_wdata,
  output logic       bus_wr,
  output logic       bus_rd,
  input  logic [7:0] bus_rdata
);
  localparam int SAW = 6;
  localparam int LAW = 10;

  typedef enum logic [1:0] {PH_CMD, PH_CMD2, PH_DATA} phase_t;

  logic [2:0] sck_q;
  logic [1:0] cs_q, mosi_q;
  logic       rise, fall, desel, byte_done;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh, hi7;
  logic [7:0] byte_in, pf, tx_sh;
  logic [LAW-1:0] addr, baddr, addr_inc;
  phase_t     phase;
  logic       is_long, is_wr, wr_p, rd_p, miso_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      cs_q   <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  assign desel     = cs_q[1];
  assign rise      = sck_q[1] & ~sck_q[2] & ~desel;
  assign fall      = ~sck_q[1] & sck_q[2] & ~desel;
  assign byte_in   = {rx_sh, mosi_q[1]};
  assign byte_done = rise && (bit_cnt == 3'd7);
  assign addr_inc  = is_long ? addr + {{(LAW-1){1'b0}}, 1'b1}
                             : {{(LAW-SAW){1'b0}}, addr[SAW-1:0] + {{(SAW-1){1'b0}}, 1'b1}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      hi7     <= '0;
      phase   <= PH_CMD;
      is_long <= 1'b0;
      is_wr   <= 1'b0;
      addr    <= '0;
      baddr   <= '0;
      bus_wdata <= '0;
      wr_p    <= 1'b0;
      rd_p    <= 1'b0;
      pf      <= '0;
      tx_sh   <= '0;
      miso_r  <= 1'b0;
    end else begin
      wr_p <= 1'b0;
      rd_p <= 1'b0;
      if (rd_p) pf <= bus_rdata;
      if (desel) begin
        bit_cnt <= '0;
        phase   <= PH_CMD;
        pf      <= '0;
        tx_sh   <= '0;
        miso_r  <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh   <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (fall) begin
          if (bit_cnt == 3'd0) begin
            miso_r <= pf[7];
            tx_sh  <= {pf[6:0], 1'b0};
          end else begin
            miso_r <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
          end
        end
        if (byte_done) begin
          case (phase)
            PH_CMD:
              if (!byte_in[7]) begin
                is_long <= 1'b0;
                is_wr   <= byte_in[0];
                addr    <= {{(LAW-SAW){1'b0}}, byte_in[SAW:1]};
                baddr   <= {{(LAW-SAW){1'b0}}, byte_in[SAW:1]};
                rd_p    <= ~byte_in[0];
                phase   <= PH_DATA;
              end else begin
                hi7   <= byte_in[6:0];
                phase <= PH_CMD2;
              end
            PH_CMD2: begin
              is_long <= 1'b1;
              is_wr   <= byte_in[4];
              addr    <= {hi7, byte_in[7:5]};
              baddr   <= {hi7, byte_in[7:5]};
              rd_p    <= ~byte_in[4];
              phase   <= PH_DATA;
            end
            default: begin
              addr <= addr_inc;
              if (is_wr) begin
                baddr     <= addr;
                bus_wdata <= byte_in;
                wr_p      <= 1'b1;
              end else begin
                baddr <= addr_inc;
                rd_p  <= 1'b1;
              end
            end
          endcase
        end
      end
    end

  assign spi_miso = miso_r;
  assign bus_long = is_long;
  assign bus_addr = baddr;
  assign bus_wr   = wr_p;
  assign bus_rd   = rd_p;

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_rd))
    else $error("write and read strobes together");
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n) bus_wr |=> !bus_wr)
    else $error("write strobe longer than one cycle");
  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) bus_rd |=> !bus_rd)
    else $error("read strobe longer than one cycle");
  p_short_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && !bus_long) |-> (bus_addr[LAW-1:SAW] == '0))
    else $error("short strobe outside 64 entries");
  p_no_strobe_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_q[1]) |-> (!bus_wr && !bus_rd))
    else $error("strobe while deselected");
  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) cs_q[1] |=> !spi_miso)
    else $error("MISO active while deselected");
endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, bus_long, bus_wr, bus_rd;
  logic [9:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] smem [64];
  logic [7:0] lmem [1024];
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];
  int checks = 0, fails = 0, wr_cnt = 0;
  bit both_seen = 1'b0, done = 1'b0;
  localparam int H = 5;

  always #2.5 clk = ~clk;

  spi_regport i_spi_regport (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .bus_long(bus_long), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

  assign bus_rdata = bus_long ? lmem[bus_addr] : smem[bus_addr[5:0]];

  always @(posedge clk) begin
    if (bus_wr) begin
      wr_cnt <= wr_cnt + 1;
      if (bus_long) lmem[bus_addr] <= bus_wdata;
      else smem[bus_addr[5:0]] <= bus_wdata;
    end
    if (bus_wr && bus_rd) both_seen <= 1'b1;
  end

  // {long, addr[9:0], data[7:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 10'h000, 8'h5A}, {1'b0, 10'h03F, 8'hC3}, {1'b0, 10'h015, 8'h81},
    {1'b1, 10'h000, 8'h3C}, {1'b1, 10'h3FF, 8'hE7}, {1'b1, 10'h2AA, 8'h01},
    {1'b1, 10'h155, 8'hFE}, {1'b1, 10'h200, 8'h99}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(H);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input bit lng, input bit wr, input logic [9:0] a,
                      input logic [3:0] lo, input int n);
    logic [7:0] r;
    cs_n = 1'b0;
    wait_clk(H);
    if (lng) begin
      spi_byte({1'b1, a[9:3]}, 8, r);
      spi_byte({a[2:0], wr, lo}, 8, r);
    end else begin
      spi_byte({1'b0, a[5:0], wr}, 8, r);
    end
    for (int k = 0; k < n; k++) begin
      spi_byte(tx_buf[k], 8, r);
      rx_buf[k] = r;
    end
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(4 * H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int wc;
    logic [7:0] r;
    for (int i = 0; i < 64; i++) smem[i] = 8'(i) ^ 8'hA5;
    for (int i = 0; i < 1024; i++) lmem[i] = 8'(i * 7) ^ 8'(i >> 8);
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R8 reset state
    chk("R8 miso", {7'd0, miso}, 8'd0);
    chk("R8 strobes", {6'd0, bus_wr, bus_rd}, 8'd0);

    // R1 R2 R3 R4: write then read back each vector
    for (int v = 0; v < 8; v++) begin
      tx_buf[0] = VEC[v][7:0];
      xfer(VEC[v][18], 1'b1, VEC[v][17:8], 4'h0, 1);
      if (VEC[v][18]) chk("R2 R3 long write", lmem[VEC[v][17:8]], VEC[v][7:0]);
      else chk("R1 R3 short write", smem[VEC[v][13:8]], VEC[v][7:0]);
      tx_buf[0] = 8'h00;
      xfer(VEC[v][18], 1'b0, VEC[v][17:8], 4'h0, 1);
      chk("R4 read back", rx_buf[0], VEC[v][7:0]);
    end

    // R5 long burst write across the top
    wc = wr_cnt;
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'h44;
    xfer(1'b1, 1'b1, 10'h3FE, 4'h0, 4);
    chk("R9 miso during write", rx_buf[1] | rx_buf[3], 8'h00);
    chk("R5 burst 3FE", lmem[10'h3FE], 8'h11);
    chk("R5 burst 3FF", lmem[10'h3FF], 8'h22);
    chk("R5 wrap 000", lmem[10'h000], 8'h33);
    chk("R5 wrap 001", lmem[10'h001], 8'h44);
    chk("R3 strobe count", 8'(wr_cnt - wc), 8'd4);

    // R4 R5 long burst read across the top
    for (int k = 0; k < 4; k++) tx_buf[k] = 8'h00;
    xfer(1'b1, 1'b0, 10'h3FE, 4'h0, 4);
    chk("R4 R5 read 3FE", rx_buf[0], 8'h11);
    chk("R4 R5 read 3FF", rx_buf[1], 8'h22);
    chk("R4 R5 read 000", rx_buf[2], 8'h33);
    chk("R4 R5 read 001", rx_buf[3], 8'h44);

    // R6 short burst wrap
    tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3;
    xfer(1'b0, 1'b1, 10'h03E, 4'h0, 3);
    chk("R6 short 3E", smem[6'h3E], 8'hA1);
    chk("R6 short 3F", smem[6'h3F], 8'hB2);
    chk("R6 short wrap 00", smem[6'h00], 8'hC3);
    for (int k = 0; k < 3; k++) tx_buf[k] = 8'h00;
    xfer(1'b0, 1'b0, 10'h03F, 4'h0, 3);
    chk("R6 short read 3F", rx_buf[0], 8'hB2);
    chk("R6 short read wrap 00", rx_buf[1], 8'hC3);
    chk("R6 short read 01", rx_buf[2], 8'h01 ^ 8'hA5);

    // R2 ignored low nibble: read with bits 3:0 all ones
    wc = wr_cnt;
    tx_buf[0] = 8'h00;
    xfer(1'b1, 1'b0, 10'h123, 4'hF, 1);
    chk("R2 low nibble read", rx_buf[0], 8'(10'h123 * 7) ^ 8'h01);
    chk("R2 no write", 8'(wr_cnt - wc), 8'd0);

    // R7 abort mid data byte
    wc = wr_cnt;
    cs_n = 1'b0;
    wait_clk(H);
    spi_byte({1'b0, 6'h10, 1'b1}, 8, r);
    spi_byte(8'hFF, 4, r);
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(4 * H);
    chk("R7 abort no strobe", 8'(wr_cnt - wc), 8'd0);
    chk("R7 abort reg kept", smem[6'h10], 8'h10 ^ 8'hA5);
    chk("R8 miso deselected", {7'd0, miso}, 8'd0);
    tx_buf[0] = 8'h00;
    xfer(1'b0, 1'b0, 10'h010, 4'h0, 1);
    chk("R7 next command decoded", rx_buf[0], 8'h10 ^ 8'hA5);

    chk("R10 strobes exclusive", {7'd0, both_seen}, 8'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule